// File: doc/BRIEF.md
# Quantised Charge-Storage Node

This block is a clocked, cycle-level model of one circuit node that carries a grounded storage capacitor of discrete size (a "well"). Each cycle it looks at the signal driven onto the node and updates the charge the well holds. The signal is a level plus a strength index. The output is the well's own dynamic state: its stored level and its dynamic strength.

A static driver moves the stored level one quantised step at a time. The node goes from 0 to U and then to 1 when charging, and from 1 to U and then to 0 when discharging. Each step lasts a number of clock cycles that grows with both the driver's attenuation and the well's size. Rising and falling steps have separate unit costs.

When no driver is present, the charge is held indefinitely. When the node is driven by another well, three cases apply:
- A smaller well has no effect.
- A larger well imposes its level on the next cycle.
- An equal well holding a different level leaves both at U.

A well of size zero stores nothing. It simply reflects the static driver.

Top module: `wellnode`

## Requirements
- R1: After reset a well of nonzero size holds level 0 and reports strength N_STR+WELL_SIZE.
- R2: Level codes are 2'b00 = 0, 2'b01 = 1, 2'b10 = U, 2'b11 = Z. A strength index below N_STR is static. Index N_STR, any index of N_STR+P_SIZE or above, and level Z are all a null drive. An index above N_STR and below N_STR+P_SIZE is a well of size index-N_STR. For a nonzero well size, node_str is always N_STR+WELL_SIZE.
- R3: A static 1 of strength s over a stored 0 gives U after Dr edges and 1 after 2*Dr edges. Dr = RISE_UNIT*(s+1)*WELL_SIZE, counted from the first edge that samples the drive.
- R4: A static 0 over a stored 1 gives U after Df edges and 0 after 2*Df edges, with Df = FALL_UNIT*(s+1)*WELL_SIZE. A static 0 over a stored U reaches 0 after Df edges.
- R5: A static U drive moves a stored 0 to U after Dr edges, and a stored 1 to U after Df edges. It then holds U.
- R6: A null drive leaves the stored level unchanged for any number of cycles.
- R7: Any change of the driven level or strength restarts the step count. The count then measures the full delay of the new drive from the first edge that samples it.
- R8: A driving well smaller than WELL_SIZE leaves the stored level unchanged.
- R9: A driving well larger than WELL_SIZE sets the stored level to its own level at the first edge that samples it.
- R10: A driving well equal to WELL_SIZE with a different level sets the stored level to U at the next edge. With the same level it changes nothing.
- R11: With WELL_SIZE = 0, each edge registers a static drive's level and strength to the outputs. Any other drive, and reset, gives (Z, N_STR).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_lvl | input | 2 | Level driven onto the node |
| drv_str | input | SW | Strength index of the drive, SW = $clog2(N_STR+P_SIZE) |
| node_lvl | output | 2 | Stored level of the well |
| node_str | output | SW | Strength of the well's output |

## Verification
Static steps land exactly D edges after the first edge that sees a new drive, and the second step lands D edges after that. Well-to-well results and the size-zero outputs land one edge after the drive is applied. Held levels are checked at chosen later offsets. The driver applies each stimulus on a falling edge and stamps every expected value with the cycle number at which it is due. The scoreboard compares each value at the falling edge that follows that cycle's rising edge. Values are also checked one cycle before each step, so an early step fails as well as a late one.

// File: rtl/wellnode_pkg.sv
package wellnode_pkg;

  typedef enum logic [1:0] {
    LV_0 = 2'b00,
    LV_1 = 2'b01,
    LV_U = 2'b10,
    LV_Z = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    DK_NULL,
    DK_STATIC,
    DK_DYN
  } drv_kind_e;

  // Cycles for one quantised step: unit cost times attenuator rank times well size.
  function automatic int step_cycles(int s, bit rising, int ru, int fu, int size);
    return (rising ? ru : fu) * (s + 1) * size;
  endfunction

  // Level reached after one step from q toward target t.
  function automatic lvl_e next_step(lvl_e q, lvl_e t);
    if (q == t) return q;
    if (q == LV_U) return t;
    return LV_U;
  endfunction

  // True when the pending step raises the node voltage.
  function automatic bit step_rises(lvl_e q, lvl_e t);
    return (q == LV_0) || (q == LV_U && t == LV_1);
  endfunction

endpackage

// File: rtl/wellnode_classify.sv
module wellnode_classify
  import wellnode_pkg::*;
#(
  parameter int N_STR  = 3,
  parameter int P_SIZE = 4,
  parameter int SW     = 3
) (
  input  logic [1:0]    drv_lvl,
  input  logic [SW-1:0] drv_str,
  output lvl_e          lvl,
  output drv_kind_e     kind,
  output logic [SW-1:0] dsize
);

  always_comb begin
    lvl   = lvl_e'(drv_lvl);
    kind  = DK_NULL;
    dsize = '0;
    if (lvl != LV_Z) begin
      if (int'(drv_str) < N_STR) begin
        kind = DK_STATIC;
      end else if (int'(drv_str) > N_STR && int'(drv_str) < N_STR + P_SIZE) begin
        kind  = DK_DYN;
        dsize = SW'(int'(drv_str) - N_STR);
      end
    end
  end

endmodule

// File: rtl/wellnode_timer.sv
module wellnode_timer
  import wellnode_pkg::*;
#(
  parameter int SW        = 3,
  parameter int WELL_SIZE = 2,
  parameter int RISE_UNIT = 2,
  parameter int FALL_UNIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          need,
  input  logic [SW-1:0] s_idx,
  input  logic          rising,
  output logic          fire
);

  localparam int TAB  = 2 ** SW;
  localparam int UMAX = (RISE_UNIT > FALL_UNIT) ? RISE_UNIT : FALL_UNIT;
  localparam int MAXD = UMAX * TAB * WELL_SIZE;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] dly_tab [TAB][2];
  logic [CW-1:0] cnt;
  logic [CW-1:0] base;
  logic [CW-1:0] limit;

  for (genvar g = 0; g < TAB; g++) begin : g_row
    for (genvar r = 0; r < 2; r++) begin : g_dir
      assign dly_tab[g][r] = CW'(step_cycles(g, r != 0, RISE_UNIT, FALL_UNIT, WELL_SIZE));
    end
  end

  assign limit = dly_tab[s_idx][rising];
  assign base  = restart ? '0 : cnt;
  assign fire  = need && ((base + CW'(1)) == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!need || fire) begin
      cnt <= '0;
    end else begin
      cnt <= base + CW'(1);
    end
  end

endmodule

// File: rtl/wellnode_core.sv
module wellnode_core
  import wellnode_pkg::*;
#(
  parameter int SW        = 3,
  parameter int WELL_SIZE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  drv_kind_e     kind,
  input  lvl_e          lvl,
  input  logic [SW-1:0] dsize,
  input  logic          fire,
  output lvl_e          q,
  output logic          need,
  output logic          rising,
  output logic          adopt_ev,
  output logic          share_ev
);

  assign need     = (kind == DK_STATIC) && (lvl != q);
  assign rising   = step_rises(q, lvl);
  assign adopt_ev = (kind == DK_DYN) && (int'(dsize) > WELL_SIZE);
  assign share_ev = (kind == DK_DYN) && (int'(dsize) == WELL_SIZE) && (lvl != q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= LV_0;
    end else if (fire) begin
      q <= next_step(q, lvl);
    end else if (adopt_ev) begin
      q <= lvl;
    end else if (share_ev) begin
      q <= LV_U;
    end
  end

endmodule

// File: rtl/wellnode.sv
module wellnode
  import wellnode_pkg::*;
#(
  parameter int N_STR     = 3,
  parameter int P_SIZE    = 4,
  parameter int WELL_SIZE = 2,
  parameter int RISE_UNIT = 2,
  parameter int FALL_UNIT = 3,
  localparam int SW       = $clog2(N_STR + P_SIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    drv_lvl,
  input  logic [SW-1:0] drv_str,
  output logic [1:0]    node_lvl,
  output logic [SW-1:0] node_str
);

  localparam logic [SW-1:0] NULL_STR = SW'(N_STR);

  lvl_e          drv_lv;
  drv_kind_e     kind;
  logic [SW-1:0] dsize;
  logic          step_ev;
  logic          adopt_ev;
  logic          share_ev;

  wellnode_classify #(.N_STR(N_STR), .P_SIZE(P_SIZE), .SW(SW)) u_cls (
    .drv_lvl(drv_lvl), .drv_str(drv_str), .lvl(drv_lv), .kind(kind), .dsize(dsize)
  );

  if (WELL_SIZE == 0) begin : g_nostore
    lvl_e          pass_q;
    logic [SW-1:0] pass_s;
    always_ff @(posedge clk) begin
      if (!rst_n || kind != DK_STATIC) begin
        pass_q <= LV_Z;
        pass_s <= NULL_STR;
      end else begin
        pass_q <= drv_lv;
        pass_s <= drv_str;
      end
    end
    assign node_lvl = pass_q;
    assign node_str = pass_s;
    assign step_ev  = 1'b0;
    assign adopt_ev = 1'b0;
    assign share_ev = 1'b0;
  end else begin : g_store
    logic [1:0]    prev_lvl;
    logic [SW-1:0] prev_str;
    logic          restart;
    logic          need;
    logic          rising;
    lvl_e          q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_lvl <= LV_Z;
        prev_str <= NULL_STR;
      end else begin
        prev_lvl <= drv_lvl;
        prev_str <= drv_str;
      end
    end
    assign restart = (drv_lvl != prev_lvl) || (drv_str != prev_str);

    wellnode_timer #(
      .SW(SW), .WELL_SIZE(WELL_SIZE), .RISE_UNIT(RISE_UNIT), .FALL_UNIT(FALL_UNIT)
    ) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(restart), .need(need),
      .s_idx(drv_str), .rising(rising), .fire(step_ev)
    );

    wellnode_core #(.SW(SW), .WELL_SIZE(WELL_SIZE)) u_core (
      .clk(clk), .rst_n(rst_n), .kind(kind), .lvl(drv_lv), .dsize(dsize),
      .fire(step_ev), .q(q), .need(need), .rising(rising),
      .adopt_ev(adopt_ev), .share_ev(share_ev)
    );

    assign node_lvl = q;
    assign node_str = SW'(N_STR + WELL_SIZE);
  end

endmodule

// File: rtl/wellnode_chk.sv
module wellnode_chk #(
  parameter int N_STR     = 3,
  parameter int P_SIZE    = 4,
  parameter int WELL_SIZE = 2,
  localparam int SW       = $clog2(N_STR + P_SIZE)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    drv_lvl,
  input logic [SW-1:0] drv_str,
  input logic [1:0]    node_lvl,
  input logic          step_ev
);

  logic is_null;
  logic is_stat;
  logic is_dyn;
  int   dsz;

  assign is_null = (drv_lvl == 2'b11) || (int'(drv_str) == N_STR) ||
                   (int'(drv_str) >= N_STR + P_SIZE);
  assign is_stat = (drv_lvl != 2'b11) && (int'(drv_str) < N_STR);
  assign is_dyn  = !is_null && !is_stat;
  assign dsz     = int'(drv_str) - N_STR;

  if (WELL_SIZE > 0) begin : g_chk
    // R6
    null_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_null |=> $stable(node_lvl));

    // R8
    small_well_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dyn && dsz < WELL_SIZE) |=> $stable(node_lvl));

    // R9
    large_well_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dyn && dsz > WELL_SIZE) |=> (node_lvl == $past(drv_lvl)));

    // R10
    share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dyn && dsz == WELL_SIZE && drv_lvl != node_lvl) |=> (node_lvl == 2'b10));

    // R3
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_ev |=> !$stable(node_lvl));

    // R4
    via_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(node_lvl) && $past(is_stat)) |-> ($past(node_lvl) == 2'b10 || node_lvl == 2'b10));
  end

endmodule

bind wellnode wellnode_chk #(
  .N_STR(N_STR), .P_SIZE(P_SIZE), .WELL_SIZE(WELL_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_lvl(drv_lvl), .drv_str(drv_str),
  .node_lvl(node_lvl), .step_ev(step_ev)
);

// File: tb/test_wellnode.sv
`timescale 1ns/1ps
module test_wellnode;

  localparam logic [1:0] L0 = 2'd0, L1 = 2'd1, LU = 2'd2, LZ = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] drv_lvl = LZ;
  logic [2:0] drv_str = 3'd3;
  logic [1:0] lvl_a, lvl_b;
  logic [2:0] str_a, str_b;
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    int         due;
    int         inst;
    logic [1:0] lvl;
    logic [2:0] str;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wellnode i_wellnode (
    .clk(clk), .rst_n(rst_n), .drv_lvl(drv_lvl), .drv_str(drv_str),
    .node_lvl(lvl_a), .node_str(str_a)
  );

  wellnode #(.WELL_SIZE(0)) i_wellnode_z (
    .clk(clk), .rst_n(rst_n), .drv_lvl(drv_lvl), .drv_str(drv_str),
    .node_lvl(lvl_b), .node_str(str_b)
  );

  // monitor: compare every item whose due cycle has been reached
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      logic [1:0] al;
      logic [2:0] as;
      al = (sb[0].inst == 0) ? lvl_a : lvl_b;
      as = (sb[0].inst == 0) ? str_a : str_b;
      compared++;
      if (al !== sb[0].lvl || as !== sb[0].str || sb[0].due != cyc) begin
        mismatched++;
        $display("FAIL %s inst%0d cyc%0d: actual lvl=%0d str=%0d expected lvl=%0d str=%0d due=%0d",
                 sb[0].tag, sb[0].inst, cyc, al, as, sb[0].lvl, sb[0].str, sb[0].due);
      end
      void'(sb.pop_front());
    end
  end

  task automatic apply(logic [1:0] l, logic [2:0] s);
    @(negedge clk);
    drv_lvl = l;
    drv_str = s;
  endtask

  task automatic expect_at(int d, int inst, logic [1:0] l, logic [2:0] s, string tag);
    exp_t e;
    e.due = cyc + d; e.inst = inst; e.lvl = l; e.str = s; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R11 size-zero reset state
    expect_at(1, 0, L0, 3'd5, "R1");
    expect_at(1, 1, LZ, 3'd3, "R11");
    drain();

    // R3: static 1, s=0, Dr=4
    apply(L1, 3'd0);
    expect_at(3, 0, L0, 3'd5, "R3");
    expect_at(4, 0, LU, 3'd5, "R3");
    expect_at(7, 0, LU, 3'd5, "R3");
    expect_at(8, 0, L1, 3'd5, "R3");
    drain();

    // R6: null by level Z, then by strength N
    apply(LZ, 3'd0);
    expect_at(20, 0, L1, 3'd5, "R6");
    drain();
    apply(L0, 3'd3);
    expect_at(10, 0, L1, 3'd5, "R6");
    drain();

    // R4: static 0, s=1, Df=12
    apply(L0, 3'd1);
    expect_at(11, 0, L1, 3'd5, "R4");
    expect_at(12, 0, LU, 3'd5, "R4");
    expect_at(23, 0, LU, 3'd5, "R4");
    expect_at(24, 0, L0, 3'd5, "R4");
    drain();

    // R7: restart when the strength changes mid-count (s=1 rise, Dr=8)
    apply(L1, 3'd0);
    @(negedge clk);
    apply(L1, 3'd1);
    expect_at(7, 0, L0, 3'd5, "R7");
    expect_at(8, 0, LU, 3'd5, "R7");
    drain();
    apply(LZ, 3'd0);

    // R4 from U: Df=6
    apply(L0, 3'd0);
    expect_at(5, 0, LU, 3'd5, "R4");
    expect_at(6, 0, L0, 3'd5, "R4");
    drain();

    // R5: static U from 0, Dr=4, then holds
    apply(LU, 3'd0);
    expect_at(3, 0, L0, 3'd5, "R5");
    expect_at(4, 0, LU, 3'd5, "R5");
    expect_at(9, 0, LU, 3'd5, "R5");
    drain();
    apply(LZ, 3'd0);

    // R8: smaller well (size 1) ignored
    apply(L1, 3'd4);
    expect_at(5, 0, LU, 3'd5, "R8");
    drain();

    // R9: larger well (size 3) adopted next edge; R11 dynamic gives Z on size zero
    apply(L1, 3'd6);
    expect_at(1, 0, L1, 3'd5, "R9");
    expect_at(1, 1, LZ, 3'd3, "R11");
    drain();

    // R10: equal size with different level shares to U; same level leaves it
    apply(L0, 3'd5);
    expect_at(1, 0, LU, 3'd5, "R10");
    drain();
    apply(LU, 3'd5);
    expect_at(3, 0, LU, 3'd5, "R10");
    drain();

    // R11: size-zero well reflects static drive one edge later
    apply(L1, 3'd2);
    expect_at(1, 1, L1, 3'd2, "R11");
    apply(L0, 3'd0);
    expect_at(1, 1, L0, 3'd0, "R11");
    apply(LZ, 3'd0);
    drain();

    // R2: strength index 7 is out of range and acts as null
    apply(L0, 3'd7);
    expect_at(5, 0, LU, 3'd5, "R2");
    expect_at(5, 1, LZ, 3'd3, "R2");
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule